// File: doc/BRIEF.md
# PLL Holdover Controller

This block decides when the charge pump of a phase-locked loop is parked in a high-impedance holdover state and when it is let out again. Holdover keeps the oscillator tuning voltage roughly where it was when the reference disappeared. Without holdover, the pump would be driven hard in one direction. Two paths can request holdover. The manual path reacts to a falling edge on an active-low sync pin. The automatic path reacts to a low lock-detect level. Both paths are gated by a global holdover enable.

Entering holdover takes effect as soon as the synchronized condition is seen. Leaving holdover is never immediate. The block waits for the next reference-path phase-detector edge, which arrives as a one-cycle pulse that is already in the block clock domain. On that edge it drops the tristate request and issues a one-cycle reset to the feedback B counter, so that the two divider outputs line up again. After an automatic holdover ends, the automatic path stays disarmed until lock has been seen again. The sync and lock-detect pins each pass through a synchronizer of `SYNC_STAGES` flops.

Top module: `holdover_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `cp_tristate_o` and `b_cnt_rst_o` are 0.
- R2: With `hold_en_i` = 0, neither a sync falling edge nor a low lock level raises `cp_tristate_o`.
- R3: Manual holdover is edge triggered. A 1-to-0 transition of `sync_ni` while enabled raises `cp_tristate_o` three clock edges after the change, counting two synchronizer stages and one state edge. A level that is already low when the block is enabled has no effect.
- R4: While `sync_ni` stays low, reference edges do not release manual holdover.
- R5: After `sync_ni` returns high, `cp_tristate_o` stays 1 until a reference edge arrives, for as long as none arrives.
- R6: A release happens on the clock edge that samples `ref_edge_i` = 1. After that edge, `cp_tristate_o` is 0 and `b_cnt_rst_o` is 1 for exactly one cycle.
- R7: With `auto_en_i` = 1, a low `lock_det_i` enters holdover with the same three-edge latency. A reference edge releases it, as in R6. With `auto_en_i` = 0, a low lock level has no effect.
- R8: With `ld_cmp_en_i` = 0, lock detect is treated as high, so automatic entry cannot occur. Re-enabling the comparator while the lock level is low enters holdover on the next clock edge.
- R9: After an automatic release, a lock level that stays low does not re-enter holdover. Once lock has been high, a new low level enters holdover again.
- R10: A sync falling edge takes priority over automatic entry. This holds when both occur in the same cycle and when the edge occurs during an automatic holdover. The result is manual holdover, which is not released while `sync_ni` is low.
- R11: Clearing `hold_en_i` during holdover drops `cp_tristate_o` on the next clock edge without a `b_cnt_rst_o` pulse.
- R12: `b_cnt_rst_o` is never 1 except in the cycle in which `cp_tristate_o` has just fallen because of a reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_en_i | input | 1 | Global holdover enable |
| auto_en_i | input | 1 | Enable for automatic (lock-loss) holdover |
| ld_cmp_en_i | input | 1 | Lock-detect comparator enable; 0 forces lock to read high |
| sync_ni | input | 1 | Active-low sync pin, asynchronous |
| lock_det_i | input | 1 | Lock-detect level, asynchronous, 1 = locked |
| ref_edge_i | input | 1 | One-cycle pulse per reference-path phase-detector edge |
| cp_tristate_o | output | 1 | Charge-pump high-impedance request |
| b_cnt_rst_o | output | 1 | One-cycle feedback B counter reset |

## Verification
Manual holdover is driven with a sync drop and then a long gap before the sync rise. Reference pulses are sent both while sync is low and after it has risen. This separates a release gated by the reference edge from a release gated by sync. A sync pin that is already low when the block is enabled tells edge detection apart from level detection. Automatic holdover is run with lock held low across a release, then raised and dropped again, to show the rearm rule. Lock is also dropped with the comparator disabled and then re-enabled. Simultaneous and overlapping manual and automatic triggers, and an enable removed mid-hold, separate the priority rule and the reset-pulse rule from ordinary release.

// File: rtl/holdover_pkg.sv
package holdover_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_HOLD_MAN  = 3'd1,
    ST_WAIT_REL  = 3'd2,
    ST_HOLD_AUTO = 3'd3,
    ST_REARM     = 3'd4
  } hold_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/hold_cond.sv
module hold_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_cmp_en_i,
  input  logic sync_ni,
  input  logic lock_det_i,
  output logic sync_hi_o,
  output logic sync_fall_o,
  output logic lock_ok_o
);
  logic sync_s, sync_d_q, lock_s;

  // both chains reset to the idle level so no false event follows reset
  hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sync_ni), .q_o(sync_s)
  );
  hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lock_det_i), .q_o(lock_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_d_q <= 1'b1;
    else         sync_d_q <= sync_s;
  end

  assign sync_hi_o   = sync_s;
  assign sync_fall_o = sync_d_q & ~sync_s;
  assign lock_ok_o   = ld_cmp_en_i ? lock_s : 1'b1;
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import holdover_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_en_i,
  input  logic auto_en_i,
  input  logic sync_hi_i,
  input  logic sync_fall_i,
  input  logic lock_ok_i,
  input  logic ref_edge_i,
  output logic tristate_o,
  output logic b_rst_o
);
  hold_state_e state_q, state_d;
  logic        rel_fire;
  logic        b_rst_q;

  always_comb begin
    state_d  = state_q;
    rel_fire = 1'b0;
    if (!hold_en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (sync_fall_i)                  state_d = ST_HOLD_MAN;
          else if (auto_en_i && !lock_ok_i) state_d = ST_HOLD_AUTO;
        end
        ST_HOLD_MAN: begin
          if (sync_hi_i) state_d = ST_WAIT_REL;
        end
        ST_WAIT_REL: begin
          if (sync_fall_i) state_d = ST_HOLD_MAN;
          else if (ref_edge_i) begin
            state_d  = ST_IDLE;
            rel_fire = 1'b1;
          end
        end
        ST_HOLD_AUTO: begin
          if (sync_fall_i) state_d = ST_HOLD_MAN;
          else if (ref_edge_i) begin
            state_d  = ST_REARM;
            rel_fire = 1'b1;
          end
        end
        ST_REARM: begin
          if (sync_fall_i)    state_d = ST_HOLD_MAN;
          else if (lock_ok_i) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      b_rst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      b_rst_q <= rel_fire;
    end
  end

  assign tristate_o = (state_q == ST_HOLD_MAN) || (state_q == ST_WAIT_REL) ||
                      (state_q == ST_HOLD_AUTO);
  assign b_rst_o    = b_rst_q;
endmodule

// File: rtl/holdover_ctrl.sv
module holdover_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_en_i,
  input  logic auto_en_i,
  input  logic ld_cmp_en_i,
  input  logic sync_ni,
  input  logic lock_det_i,
  input  logic ref_edge_i,
  output logic cp_tristate_o,
  output logic b_cnt_rst_o
);
  logic sync_hi, sync_fall, lock_ok;

  hold_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_cmp_en_i(ld_cmp_en_i),
    .sync_ni    (sync_ni),
    .lock_det_i (lock_det_i),
    .sync_hi_o  (sync_hi),
    .sync_fall_o(sync_fall),
    .lock_ok_o  (lock_ok)
  );

  hold_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_en_i  (hold_en_i),
    .auto_en_i  (auto_en_i),
    .sync_hi_i  (sync_hi),
    .sync_fall_i(sync_fall),
    .lock_ok_i  (lock_ok),
    .ref_edge_i (ref_edge_i),
    .tristate_o (cp_tristate_o),
    .b_rst_o    (b_cnt_rst_o)
  );
endmodule

// File: rtl/holdover_ctrl_chk.sv
module holdover_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_en_i,
  input logic ref_edge_i,
  input logic cp_tristate_o,
  input logic b_cnt_rst_o
);
  assert_pulse_on_fall_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_cnt_rst_o |-> (!cp_tristate_o && $past(cp_tristate_o) && $past(ref_edge_i)));

  assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_cnt_rst_o |=> !b_cnt_rst_o);

  assert_disabled_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_en_i |=> !cp_tristate_o);

  assert_rise_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cp_tristate_o) |-> $past(hold_en_i));

  assert_release_on_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cp_tristate_o) && $past(hold_en_i)) |-> ($past(ref_edge_i) && b_cnt_rst_o));

  assert_disable_no_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hold_en_i) |-> !b_cnt_rst_o);
endmodule

bind holdover_ctrl holdover_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hold_en_i    (hold_en_i),
  .ref_edge_i   (ref_edge_i),
  .cp_tristate_o(cp_tristate_o),
  .b_cnt_rst_o  (b_cnt_rst_o)
);

// File: tb/holdover_ctrl_tb.sv
`timescale 1ns/1ps
module holdover_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_en = 1'b1, auto_en = 1'b0, cmp_en = 1'b1;
  logic sync_n = 1'b1, lock = 1'b1, ref_edge = 1'b0;
  logic tri_o, brst_o;
  int   n_checks = 0, n_errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  holdover_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hold_en_i(hold_en), .auto_en_i(auto_en),
    .ld_cmp_en_i(cmp_en), .sync_ni(sync_n), .lock_det_i(lock),
    .ref_edge_i(ref_edge), .cp_tristate_o(tri_o), .b_cnt_rst_o(brst_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle reference pulse; returns at the negedge after it was sampled
  task automatic pulse_ref();
    ref_edge = 1'b1;
    @(negedge clk);
    ref_edge = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 tristate during reset", tri_o, 1'b0);
    chk("R1 brst during reset", brst_o, 1'b0);
    wait_n(1);
    rst_n = 1'b1;
    wait_n(3);
    chk("R1 tristate after reset", tri_o, 1'b0);
    chk("R1 brst after reset", brst_o, 1'b0);
  endtask

  task automatic t_disabled();
    hold_en = 1'b0; auto_en = 1'b1; sync_n = 1'b0; lock = 1'b0;
    wait_n(6);
    chk("R2 no hold when disabled", tri_o, 1'b0);
    auto_en = 1'b0; lock = 1'b1; hold_en = 1'b1;
    wait_n(6);
    chk("R3 low level alone no entry", tri_o, 1'b0);
    sync_n = 1'b1;
    wait_n(4);
  endtask

  task automatic t_manual();
    sync_n = 1'b0;
    wait_n(2);
    chk("R3 not yet after two edges", tri_o, 1'b0);
    wait_n(1);
    chk("R3 manual entry", tri_o, 1'b1);
    pulse_ref();
    chk("R4 ref ignored while sync low", tri_o, 1'b1);
    chk("R4 no pulse while sync low", brst_o, 1'b0);
    sync_n = 1'b1;
    wait_n(50);
    chk("R5 held without ref edge", tri_o, 1'b1);
    pulse_ref();
    chk("R6 released on ref edge", tri_o, 1'b0);
    chk("R6 b reset pulse", brst_o, 1'b1);
    wait_n(1);
    chk("R6 pulse one cycle", brst_o, 1'b0);
  endtask

  task automatic t_auto();
    auto_en = 1'b1; lock = 1'b0;
    wait_n(3);
    chk("R7 auto entry", tri_o, 1'b1);
    pulse_ref();
    chk("R7 auto release", tri_o, 1'b0);
    chk("R7 auto b reset", brst_o, 1'b1);
    wait_n(20);
    chk("R9 no retrigger while unlocked", tri_o, 1'b0);
    lock = 1'b1;
    wait_n(4);
    lock = 1'b0;
    wait_n(3);
    chk("R9 rearmed entry", tri_o, 1'b1);
    pulse_ref();
    lock = 1'b1;
    wait_n(5);
    auto_en = 1'b0; lock = 1'b0;
    wait_n(6);
    chk("R7 auto disabled no entry", tri_o, 1'b0);
    lock = 1'b1;
    wait_n(4);
  endtask

  task automatic t_cmp_off();
    auto_en = 1'b1; cmp_en = 1'b0; lock = 1'b0;
    wait_n(8);
    chk("R8 comparator off reads locked", tri_o, 1'b0);
    cmp_en = 1'b1;
    wait_n(1);
    chk("R8 comparator on enters", tri_o, 1'b1);
    pulse_ref();
    lock = 1'b1;
    wait_n(5);
    chk("R8 back to idle", tri_o, 1'b0);
  endtask

  task automatic t_priority();
    lock = 1'b0; sync_n = 1'b0;
    wait_n(3);
    chk("R10 simultaneous entry", tri_o, 1'b1);
    pulse_ref();
    chk("R10 simultaneous is manual", tri_o, 1'b1);
    sync_n = 1'b1; lock = 1'b1;
    wait_n(4);
    pulse_ref();
    chk("R10 released after sync high", tri_o, 1'b0);
    wait_n(2);
    lock = 1'b0;
    wait_n(3);
    chk("R10 auto hold before sync", tri_o, 1'b1);
    sync_n = 1'b0;
    wait_n(3);
    pulse_ref();
    chk("R10 sync overrides auto", tri_o, 1'b1);
    sync_n = 1'b1; lock = 1'b1;
    wait_n(4);
    pulse_ref();
    chk("R10 final release", tri_o, 1'b0);
    chk("R10 final b reset", brst_o, 1'b1);
    auto_en = 1'b0;
    wait_n(2);
  endtask

  task automatic t_disable_mid();
    sync_n = 1'b0;
    wait_n(3);
    chk("R11 in hold", tri_o, 1'b1);
    hold_en = 1'b0;
    wait_n(1);
    chk("R11 dropped by disable", tri_o, 1'b0);
    chk("R11 no b reset on disable", brst_o, 1'b0);
    sync_n = 1'b1;
    wait_n(4);
    hold_en = 1'b1;
    wait_n(4);
    chk("R11 stays idle", tri_o, 1'b0);
    chk("R12 no stray pulse", brst_o, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_disabled();
    t_manual();
    t_auto();
    t_cmp_off();
    t_priority();
    t_disable_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule